// File: doc/BRIEF.md
# Velocity Keyboard Matrix Scanner

This block scans a diode-isolated key matrix in which every key carries two contacts, one that closes early in the key travel and one that closes late. It selects one of eight column drive lines at a time through a decoded, active-low select. While a column is selected it reads seven contact pairs, one pair per key group. The inputs idle high through external pull-ups, so a closed contact reads low.

A single pacing counter sets how long each column stays selected. The counter length comes from the clock frequency and the wanted full-scan rate, which is 2 kHz by default. After a column changes, the block waits a programmable number of clocks so that the line capacitance can settle. It then emits one sample per key group on consecutive cycles. The group inputs are wired in reversed bit order, so the walk starts at the most significant input bit.

Each sample turns the group and the column into a key position. A note table, built at elaboration, maps that position to a note number. A strobe carries the note number together with both contact states as active-high flags. Positions beyond the fitted keys produce no strobe. Measuring the time between the two contacts for velocity is left to the logic that receives these samples.

Top module: `keymatrix_scan`

## Requirements
- R1: While reset is asserted and in the cycle after its release, exactly column 0 is selected (`col_sel_n` = 8'hFE) and `key_vld` is low.
- R2: Exactly one bit of `col_sel_n` is low at all times. Bit i low means column i is driven.
- R3: Each column stays selected for exactly TICK_DIV = CLK_HZ/(SCAN_HZ*COLS) clocks. The columns step 0,1,...,7 and then wrap back to 0, so a full scan takes COLS*TICK_DIV clocks.
- R4: Let cycle 0 be the first cycle in which a column is selected. No strobe appears before cycle SETTLE_CLKS+1. The strobe for logical group g appears in cycle SETTLE_CLKS+1+g, for g = 0..GROUPS-1.
- R5: Logical group g is read from input bit GROUPS-1-g of `grp_first_n` and `grp_second_n`, so the walk starts at the most significant bit. The key position is g*COLS + column.
- R6: `key_first` is the inverse of the sampled `grp_first_n` bit and `key_second` is the inverse of the sampled `grp_second_n` bit, independent of each other. Both flags are low whenever `key_vld` is low.
- R7: `key_note` is the table entry for the key position. The default table gives BASE_NOTE + position, with BASE_NOTE = 36.
- R8: Positions numbered NUM_KEYS (49) and above never raise `key_vld`.
- R9: `key_vld` is high for exactly one cycle per fitted position, and no two positions share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_sel_n | output | COLS (8) | Column drive lines; the selected column is low |
| grp_first_n | input | GROUPS (7) | First-contact inputs, active low, bit order reversed |
| grp_second_n | input | GROUPS (7) | Second-contact inputs, active low, bit order reversed |
| key_vld | output | 1 | One-cycle sample strobe |
| key_note | output | 7 | Mapped note number for the strobe |
| key_first | output | 1 | First contact closed (active high) |
| key_second | output | 1 | Second contact closed (active high) |

## Verification
A wrong pacing count shows up at the end of the first column's dwell. The select lines change in the wrong cycle, or to a column other than the next one. A slot counter that is off by one shifts the strobes into the settle window. The bench holds the inputs at the wrong value for the first SETTLE_CLKS cycles of each column, so an early sample returns inverted contact flags within the first column. A reversed walk, a wrong position formula or a wrong table entry gives a wrong note number on the very first strobe whose expected note differs. A missing range limit raises a strobe for one of positions 49 to 55 in the scan that presses only those keys.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

   localparam int NOTE_BITS = 7;
   localparam int MAP_SLOTS = 64;

   typedef logic [NOTE_BITS-1:0] note_t;

   // Linear position-to-note table; each slot holds base + position.
   function automatic logic [MAP_SLOTS*NOTE_BITS-1:0] linear_map(input int base);
      logic [MAP_SLOTS*NOTE_BITS-1:0] m;
      m = '0;
      for (int p = 0; p < MAP_SLOTS; p++) begin
         m[p*NOTE_BITS +: NOTE_BITS] = NOTE_BITS'(base + p);
      end
      return m;
   endfunction

endpackage

// File: rtl/keyscan_pacer.sv
module keyscan_pacer #(
   parameter int TICK_DIV    = 16,
   parameter int SETTLE_CLKS = 3,
   parameter int GROUPS      = 7,
   parameter int COL_W       = 3,
   parameter int GRP_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [COL_W-1:0] col,
   output logic             slot_vld,
   output logic [GRP_W-1:0] slot
);
   localparam int DIV_W = $clog2(TICK_DIV);

   logic [DIV_W-1:0] phase;

   // One counter paces the columns and also gives the phase inside a column.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= '0;
         col   <= '0;
      end else if (phase == DIV_W'(TICK_DIV - 1)) begin
         phase <= '0;
         col   <= col + 1'b1;
      end else begin
         phase <= phase + 1'b1;
      end
   end

   always_comb begin
      slot_vld = (phase >= DIV_W'(SETTLE_CLKS)) &&
                 (phase <  DIV_W'(SETTLE_CLKS + GROUPS));
      slot     = GRP_W'(phase - DIV_W'(SETTLE_CLKS));
   end

endmodule

// File: rtl/keyscan_coldec.sv
module keyscan_coldec #(
   parameter int COLS  = 8,
   parameter int COL_W = 3
) (
   input  logic [COL_W-1:0] col,
   output logic [COLS-1:0]  sel_n
);
   for (genvar i = 0; i < COLS; i++) begin : g_line
      assign sel_n[i] = (col != COL_W'(i));
   end
endmodule

// File: rtl/keyscan_notemap.sv
module keyscan_notemap
   import keyscan_pkg::*;
#(
   parameter int POS_W     = 6,
   parameter int NUM_KEYS  = 49,
   parameter int BASE_NOTE = 36,
   parameter bit USE_TABLE = 1'b1,
   parameter logic [MAP_SLOTS*NOTE_BITS-1:0] NOTE_MAP = linear_map(36)
) (
   input  logic [POS_W-1:0] pos,
   output note_t            note,
   output logic             fitted
);
   assign fitted = ({1'b0, pos} < (POS_W+1)'(NUM_KEYS));

   if (USE_TABLE) begin : g_table
      assign note = NOTE_MAP[NOTE_BITS*int'(pos) +: NOTE_BITS];
   end else begin : g_offset
      assign note = NOTE_BITS'(BASE_NOTE) + NOTE_BITS'(pos);
   end
endmodule

// File: rtl/keymatrix_scan.sv
module keymatrix_scan
   import keyscan_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int SCAN_HZ     = 2000,
   parameter int COLS        = 8,
   parameter int GROUPS      = 7,
   parameter int SETTLE_CLKS = 16,
   parameter int NUM_KEYS    = 49,
   parameter int BASE_NOTE   = 36,
   parameter bit USE_TABLE   = 1'b1,
   parameter logic [MAP_SLOTS*NOTE_BITS-1:0] NOTE_MAP = linear_map(36)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   output logic [COLS-1:0]      col_sel_n,
   input  logic [GROUPS-1:0]    grp_first_n,
   input  logic [GROUPS-1:0]    grp_second_n,
   output logic                 key_vld,
   output logic [NOTE_BITS-1:0] key_note,
   output logic                 key_first,
   output logic                 key_second
);
   localparam int COL_W    = $clog2(COLS);
   localparam int GRP_W    = $clog2(GROUPS);
   localparam int POS_W    = COL_W + GRP_W;
   localparam int TICK_DIV = CLK_HZ / (SCAN_HZ * COLS);

   if ((1 << COL_W) != COLS) begin : g_bad_cols
      $error("COLS must be a power of two");
   end
   if (TICK_DIV < SETTLE_CLKS + GROUPS + 1) begin : g_bad_div
      $error("column dwell too short for settle time plus group walk");
   end
   if (NUM_KEYS > COLS * GROUPS) begin : g_bad_keys
      $error("NUM_KEYS exceeds matrix positions");
   end
   if (USE_TABLE && (COLS << GRP_W) > MAP_SLOTS) begin : g_bad_map
      $error("note table too small for matrix");
   end

   logic [COL_W-1:0] col;
   logic             slot_vld;
   logic [GRP_W-1:0] slot;
   logic [GRP_W-1:0] bit_idx;
   logic [POS_W-1:0] pos;
   note_t            note;
   logic             fitted;
   logic             take;

   keyscan_pacer #(
      .TICK_DIV   (TICK_DIV),
      .SETTLE_CLKS(SETTLE_CLKS),
      .GROUPS     (GROUPS),
      .COL_W      (COL_W),
      .GRP_W      (GRP_W)
   ) u_pacer (
      .clk     (clk),
      .rst_n   (rst_n),
      .col     (col),
      .slot_vld(slot_vld),
      .slot    (slot)
   );

   keyscan_coldec #(
      .COLS (COLS),
      .COL_W(COL_W)
   ) u_dec (
      .col  (col),
      .sel_n(col_sel_n)
   );

   // Reversed wiring: the first logical group sits on the top input bit.
   assign bit_idx = GRP_W'(GROUPS - 1) - slot;
   assign pos     = {slot, col};

   keyscan_notemap #(
      .POS_W    (POS_W),
      .NUM_KEYS (NUM_KEYS),
      .BASE_NOTE(BASE_NOTE),
      .USE_TABLE(USE_TABLE),
      .NOTE_MAP (NOTE_MAP)
   ) u_map (
      .pos   (pos),
      .note  (note),
      .fitted(fitted)
   );

   assign take = slot_vld & fitted;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_vld    <= 1'b0;
         key_note   <= '0;
         key_first  <= 1'b0;
         key_second <= 1'b0;
      end else begin
         key_vld    <= take;
         key_note   <= take ? note : '0;
         key_first  <= take & ~grp_first_n[bit_idx];
         key_second <= take & ~grp_second_n[bit_idx];
      end
   end

endmodule

// File: rtl/keyscan_checker.sv
module keyscan_checker #(
   parameter int COLS        = 8,
   parameter int GROUPS      = 7,
   parameter int TICK_DIV    = 16,
   parameter int SETTLE_CLKS = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic [COLS-1:0] col_sel_n,
   input logic            key_vld,
   input logic            key_first,
   input logic            key_second
);
   localparam int CW = $clog2(TICK_DIV + 2) + 1;

   logic [COLS-1:0] prev_sel;
   logic [CW-1:0]   age;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_sel <= {{(COLS-1){1'b1}}, 1'b0};
         age      <= '0;
      end else begin
         prev_sel <= col_sel_n;
         age      <= (col_sel_n != prev_sel) ? CW'(1) : age + 1'b1;
      end
   end

   // R2: exactly one drive line low
   p_one_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~col_sel_n) == 1);

   // R3: a change only after the full dwell, and only to the next column
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (col_sel_n != prev_sel) |->
         (age == CW'(TICK_DIV)) &&
         (col_sel_n == {prev_sel[COLS-2:0], prev_sel[COLS-1]}));

   // R3: no column outlives its dwell
   p_dwell_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (col_sel_n == prev_sel) |-> (age < CW'(TICK_DIV)));

   // R4: strobes only inside the post-settle window
   p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      key_vld |-> (age >= CW'(SETTLE_CLKS + 1)) &&
                  (age <= CW'(SETTLE_CLKS + GROUPS)));

   // R6: flags are quiet between strobes
   p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !key_vld |-> (!key_first && !key_second));

endmodule

bind keymatrix_scan keyscan_checker #(
   .COLS       (COLS),
   .GROUPS     (GROUPS),
   .TICK_DIV   (TICK_DIV),
   .SETTLE_CLKS(SETTLE_CLKS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .col_sel_n (col_sel_n),
   .key_vld   (key_vld),
   .key_first (key_first),
   .key_second(key_second)
);

// File: tb/keymatrix_scan_bench.sv
module keymatrix_scan_bench;
   localparam int CLK_PERIOD = 10;
   localparam int TICK       = 16;
   localparam int SETTLE     = 3;
   localparam int NCOL       = 8;
   localparam int NGRP       = 7;
   localparam int NKEYS      = 49;
   localparam int BASE       = 36;
   localparam int SCAN       = NCOL * TICK;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] col_sel_n;
   logic [6:0] grp_first_n, grp_second_n;
   logic       key_vld, key_first, key_second;
   logic [6:0] key_note;

   logic [55:0] pf = '0, ps = '0;
   logic [7:0]  prev;
   int          age;
   int          mode = 0;
   int          total = 0, bad = 0;
   bit          finished = 1'b0;

   keymatrix_scan #(
      .CLK_HZ     (2000 * NCOL * TICK),
      .SCAN_HZ    (2000),
      .SETTLE_CLKS(SETTLE)
   ) u_keymatrix_scan (
      .clk         (clk),
      .rst_n       (rst_n),
      .col_sel_n   (col_sel_n),
      .grp_first_n (grp_first_n),
      .grp_second_n(grp_second_n),
      .key_vld     (key_vld),
      .key_note    (key_note),
      .key_first   (key_first),
      .key_second  (key_second)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int idx_of(input logic [7:0] s);
      for (int i = 0; i < NCOL; i++) if (s == ~(8'b1 << i)) return i;
      return -1;
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   // Bench-side column age: 1 in the first full cycle after a change.
   always @(posedge clk) begin
      if (!rst_n) begin
         prev <= 8'hFE;
         age  <= 0;
      end else begin
         prev <= col_sel_n;
         age  <= (col_sel_n != prev) ? 1 : age + 1;
      end
   end

   // Matrix model: reversed bit order, lines read wrong until settled.
   always_comb begin
      automatic int  c     = idx_of(col_sel_n);
      automatic bit  fresh = (col_sel_n != prev) || (age < SETTLE);
      for (int b = 0; b < NGRP; b++) begin
         automatic int p = (NGRP - 1 - b) * NCOL + ((c < 0) ? 0 : c);
         grp_first_n[b]  = fresh ? pf[p] : ~pf[p];
         grp_second_n[b] = fresh ? ps[p] : ~ps[p];
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         automatic int c  = idx_of(col_sel_n);
         automatic int g  = age - SETTLE - 1;
         automatic bit ev = (g >= 0) && (g < NGRP) && (c >= 0) && (g*NCOL + c < NKEYS);
         chk("R2 one column low", 64'(c >= 0), 64'd1);
         if (col_sel_n != prev) begin
            chk("R3 next column", 64'(c), 64'((idx_of(prev) + 1) % NCOL));
            chk("R3 dwell", 64'(age), 64'(TICK));
         end
         chk("R4 R8 R9 strobe", 64'(key_vld), 64'(ev));
         if (ev) begin
            automatic int p = g*NCOL + c;
            chk("R5 R7 note", 64'(key_note), 64'(BASE + p));
            chk("R6 first", 64'(key_first), 64'(pf[p]));
            chk("R6 second", 64'(key_second), 64'(ps[p]));
         end else begin
            chk("R6 idle flags", 64'({key_first, key_second}), 64'd0);
         end
         if (age == 12) begin
            case (mode)
               0: begin pf = '0; ps = '0; end
               1: begin pf = '1; ps = '1; end
               2: begin pf = '1; ps = '0; end
               3: begin pf = 56'hFE << 48; ps = pf; end   // R8: only positions 49..55
               4: begin pf = (56'd1 << 48) | 56'd1; ps = 56'd1 << 48; end
               default: begin
                  pf = {$urandom, $urandom};
                  ps = pf & {$urandom, $urandom};
                  if ($urandom % 4 == 0) ps = ps | 56'({$urandom, $urandom});
               end
            endcase
         end
      end
   end

   initial begin
      void'($urandom(32'd90417));
      rst_n = 1'b0;
      repeat (3) @(negedge clk) begin
         chk("R1 reset select", 64'(col_sel_n), 64'hFE);
         chk("R1 reset strobe", 64'(key_vld), 64'd0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 first column after reset", 64'(col_sel_n), 64'hFE);
      for (int m = 0; m < 5; m++) begin
         mode = m;
         repeat (2 * SCAN) @(negedge clk);
      end
      mode = 5;
      repeat (30 * SCAN) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         bad++;
         $display("FAIL watchdog got=%0d exp=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule